// File: doc/BRIEF.md
# Two-Wire Slave Byte Store with Page Buffer

This block is the slave side of a small byte store: 128 bytes reached over a two-wire serial bus with a shared clock line and an open-drain data line. It watches the bus for START and STOP conditions, answers only to the fixed 7-bit code 1010000, and keeps a 7-bit byte pointer that the master loads with a word address and that advances as bytes are read or written. Writes collect up to eight bytes in a page buffer. The buffer is committed to the array only after the STOP that ends the transfer, during a busy period whose length is a parameter in system clock cycles.

Writes have two gates. An active-low protect input vetoes every change to the array. A separate enable-level input must stay high from the START to the STOP of the write. While the busy period runs, the block never pulls the data line, so a master polling with the device code sees no acknowledge until the commit is done. Reads stream bytes from the pointer onward for as long as the master keeps acknowledging.

The data line is modelled as an input (the resolved line level) and a pull-down output. Both bus lines are sampled on the system clock.

Top module: `i2c_page_eeprom`

## Requirements
- R1: SDA falling while SCL is high (START) begins reception of a control byte. SDA rising while SCL is high (STOP) ends any transfer, releases SDA and returns the block to idle. A transfer that stops before any data byte leaves the array unchanged.
- R2: A control byte whose upper seven bits are 1010000 is acknowledged by holding SDA low for the ninth clock; bit 0 selects read (1) or write (0). Any other code gets no acknowledge, and the block stays silent until the next START.
- R3: In a write, the byte after the control byte is the word address. Its low 7 bits load the pointer (bit 7 is ignored), and it is acknowledged.
- R4: Every write data byte is acknowledged and buffered at page offset (start + i) mod 8 inside the page of the start address. When more than eight bytes arrive, the oldest are overwritten first, so the last eight are kept.
- R5: A STOP after at least one data byte starts a busy period of WR_CYCLES clocks that commits the buffered bytes to their page addresses. After a write, the pointer sits just after the last byte written, wrapping inside the page.
- R6: During the busy period, SDA is never pulled low, not even to acknowledge the block's own code.
- R7: A write is committed only if the enable level stayed high from START through STOP. A low level at any point discards the write. Changing the level during the busy period does not abort the commit.
- R8: With the protect input low at STOP, no byte of the array changes.
- R9: In a read, bytes go out MSB first starting at the pointer, with SDA changing only while SCL is low. The pointer advances per byte and wraps from 0x7F to 0x00. A master acknowledge fetches the next byte; a missing acknowledge leaves SDA released.
- R10: A repeated START is handled like a fresh START, and it discards write bytes that were buffered but not yet followed by a STOP.
- R11: After reset, SDA is released, the pointer is 0 and every byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Resolved bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| protect_n_i | input | 1 | Active-low write protect for the whole array |
| wr_gate_i | input | 1 | Enable level that must be high throughout a write |

## Verification
The assertions assume that SCL and SDA are free of glitches and hold each level for several system clocks. They also assume that the master changes SDA only while SCL is low, except to form START and STOP, and never drives a START or STOP while the block is pulling the line. The bench's master keeps within this by building every bus phase from three system clocks. It changes lines only on the falling system clock edge and releases SDA whenever the block may drive it. Random writes of 1 to 12 bytes, with random gate and protect settings, are mixed with directed cases: wrong device code, address bit 7 set, polling during the busy period, a repeated START over buffered data, and pointer wrap at 0x7F.

// File: rtl/i2ce_pkg.sv
package i2ce_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_ADDR,
        PH_WDATA,
        PH_ACK,
        PH_TX,
        PH_RACK
    } phase_e;
endpackage

// File: rtl/i2ce_line_det.sv
module i2ce_line_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    lines_t lines_d, lines_q;

    always_comb begin
        lines_d.scl = scl_i;
        lines_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '{scl: 1'b1, sda: 1'b1};
        else        lines_q <= lines_d;
    end

    assign start_o = lines_q.scl && scl_i && lines_q.sda && !sda_i;
    assign stop_o  = lines_q.scl && scl_i && !lines_q.sda && sda_i;
    assign rise_o  = !lines_q.scl && scl_i;
    assign fall_o  = lines_q.scl && !scl_i;
endmodule

// File: rtl/i2ce_page_buf.sv
module i2ce_page_buf #(
    parameter int PW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [PW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] ridx,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    localparam int SLOTS = 1 << PW;

    logic [DW-1:0]    slot_d [SLOTS];
    logic [DW-1:0]    slot_q [SLOTS];
    logic [SLOTS-1:0] vld_d, vld_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            vld_d[g]  = clr ? 1'b0 : vld_q[g];
            if (we && widx == PW'(g)) begin
                slot_d[g] = wdata;
                vld_d[g]  = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
                vld_q[g]  <= 1'b0;
            end else begin
                slot_q[g] <= slot_d[g];
                vld_q[g]  <= vld_d[g];
            end
        end
    end

    assign rdata  = slot_q[ridx];
    assign rvalid = vld_q[ridx];

    // R4: a buffered byte lands in its slot; later bytes to the same slot replace it
    a_r4_slot_holds_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (vld_q[$past(widx)] && slot_q[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/i2ce_array.sv
module i2ce_array #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/i2c_page_eeprom.sv
module i2c_page_eeprom
    import i2ce_pkg::*;
#(
    parameter int         AW        = 7,
    parameter int         PW        = 3,
    parameter int         WR_CYCLES = 1000,
    parameter logic [6:0] DEV_CODE  = 7'b1010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o,
    input  logic protect_n_i,
    input  logic wr_gate_i
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    localparam int IW = PW + 1;

    typedef struct packed {
        phase_e            ph;
        phase_e            ret;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [AW-1:0]     ptr;
        logic              pull;
        logic              mack;
        logic              gate_ok;
        logic              pend;
        logic [CW-1:0]     busy;
        logic [IW-1:0]     cidx;
    } st_t;

    st_t q, d;

    logic start_w, stop_w, rise_w, fall_w;
    logic buf_clr, buf_we, buf_rv, mem_we;
    logic [BYTE_W-1:0] buf_rd, mem_rd;

    i2ce_line_det u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w)
    );

    i2ce_page_buf #(.PW(PW), .DW(BYTE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .widx(q.ptr[PW-1:0]), .wdata(q.sh),
        .ridx(q.cidx[PW-1:0]), .rdata(buf_rd), .rvalid(buf_rv)
    );

    assign mem_we = (q.busy != '0) && !q.cidx[PW] && buf_rv;

    i2ce_array #(.AW(AW), .DW(BYTE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we),
        .waddr({q.ptr[AW-1:PW], q.cidx[PW-1:0]}), .wdata(buf_rd),
        .raddr(q.ptr), .rdata(mem_rd)
    );

    always_comb begin
        d       = q;
        buf_we  = 1'b0;
        buf_clr = 1'b0;
        if (q.busy != '0) begin
            d.busy = q.busy - CW'(1);
            if (!q.cidx[PW]) d.cidx = q.cidx + IW'(1);
        end
        if (!wr_gate_i && q.ph != PH_IDLE) d.gate_ok = 1'b0;

        if (q.busy != '0) begin
            d.ph   = PH_IDLE;
            d.pull = 1'b0;
        end else if (start_w) begin
            d.ph      = PH_CTRL;
            d.cnt     = '0;
            d.pull    = 1'b0;
            d.gate_ok = wr_gate_i;
            d.pend    = 1'b0;
            buf_clr   = 1'b1;
        end else if (stop_w) begin
            d.ph   = PH_IDLE;
            d.pull = 1'b0;
            d.pend = 1'b0;
            if (q.pend && q.gate_ok && wr_gate_i && protect_n_i) begin
                d.busy = CW'(WR_CYCLES);
                d.cidx = '0;
            end
        end else begin
            case (q.ph)
                PH_CTRL, PH_ADDR, PH_WDATA: begin
                    if (rise_w && q.cnt != 4'd8) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall_w && q.cnt == 4'd8) begin
                        d.ph   = PH_ACK;
                        d.pull = 1'b1;
                        d.ret  = PH_WDATA;
                        if (q.ph == PH_CTRL) begin
                            d.ret = q.sh[0] ? PH_TX : PH_ADDR;
                            if (q.sh[7:1] != DEV_CODE) begin
                                d.ph   = PH_IDLE;
                                d.pull = 1'b0;
                            end
                        end else if (q.ph == PH_ADDR) begin
                            d.ptr = q.sh[AW-1:0];
                        end else begin
                            buf_we = 1'b1;
                            d.ptr  = {q.ptr[AW-1:PW], q.ptr[PW-1:0] + PW'(1)};
                            d.pend = 1'b1;
                        end
                    end
                end
                PH_ACK: begin
                    if (fall_w) begin
                        d.cnt  = '0;
                        d.ph   = q.ret;
                        d.pull = 1'b0;
                        if (q.ret == PH_TX) begin
                            d.sh   = mem_rd;
                            d.ptr  = q.ptr + AW'(1);
                            d.pull = !mem_rd[BYTE_W-1];
                        end
                    end
                end
                PH_TX: begin
                    if (fall_w) begin
                        if (q.cnt == 4'd7) begin
                            d.ph   = PH_RACK;
                            d.pull = 1'b0;
                        end else begin
                            d.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                            d.cnt  = q.cnt + 4'd1;
                            d.pull = !q.sh[BYTE_W-2];
                        end
                    end
                end
                PH_RACK: begin
                    if (rise_w) begin
                        d.mack = !sda_i;
                    end else if (fall_w) begin
                        if (q.mack) begin
                            d.ph   = PH_TX;
                            d.cnt  = '0;
                            d.sh   = mem_rd;
                            d.ptr  = q.ptr + AW'(1);
                            d.pull = !mem_rd[BYTE_W-1];
                        end else begin
                            d.ph = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.ph      <= PH_IDLE;
            q.ret     <= PH_IDLE;
            q.gate_ok <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;

    // R6: the line stays released while the commit runs
    a_r6_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy != '0) |-> !sda_pull_o);

    // R5: a busy period only ever starts from a detected STOP
    a_r5_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy != '0 && $past(q.busy) == '0) |-> $past(stop_w));

    // R7 R8: a commit starts only with the gate high and protect released
    a_r7_gate_and_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy != '0 && $past(q.busy) == '0) |-> ($past(wr_gate_i) && $past(protect_n_i)));

    // R9: the block moves SDA only while SCL is low
    a_r9_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !$past(scl_i));

    // R1: an idle-time START always opens a control byte
    a_r1_start_opens_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && q.busy == '0) |=> (q.ph == PH_CTRL && q.cnt == '0));
endmodule

// File: tb/i2c_page_eeprom_bench.sv
module i2c_page_eeprom_bench;
    localparam int WRC = 200;
    localparam int Q   = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl = 1'b1, msda = 1'b1, prot_n = 1'b1, gate = 1'b1;
    logic sda_pull;
    wire  sda_line = msda & ~sda_pull;

    i2c_page_eeprom #(.WR_CYCLES(WRC)) u_i2c_page_eeprom (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .protect_n_i(prot_n), .wr_gate_i(gate)
    );

    int checks = 0, errors = 0;
    logic [7:0] model [128];
    int mptr = 0;
    logic [7:0] wbytes [16];
    bit done = 0;

    function automatic int page_addr(int a, int i);
        return (a & 'h78) | ((a + i) & 7);
    endfunction

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_x(input logic b, output logic s);
        msda = b; wt(Q);
        scl = 1'b1; wt(Q);
        s = sda_line; wt(Q);
        scl = 1'b0; wt(Q);
    endtask

    task automatic start_c;
        msda = 1'b1; wt(Q);
        scl = 1'b1; wt(Q);
        msda = 1'b0; wt(Q);
        scl = 1'b0; wt(Q);
    endtask

    task automatic stop_c;
        msda = 1'b0; wt(Q);
        scl = 1'b1; wt(Q);
        msda = 1'b1; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_x(v[i], s);
        bit_x(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 0; i < 8; i++) begin
            bit_x(1'b1, s);
            v = {v[6:0], s};
        end
        bit_x(!mack, s);
    endtask

    // write n bytes from wbytes at address a; drop_gate pulses the enable level low
    task automatic write_tx(int a, int n, bit drop_gate);
        logic ack;
        logic [7:0] pg [8];
        logic [7:0] slot_vld;
        start_c;
        send_byte(8'hA0, ack); chk("R2 write code ack", ack, 1);
        send_byte(8'(a), ack); chk("R3 address ack", ack, 1);
        slot_vld = '0;
        for (int i = 0; i < n; i++) begin
            send_byte(wbytes[i], ack); chk("R4 data ack", ack, 1);
            pg[(a + i) & 7] = wbytes[i];
            slot_vld[(a + i) & 7] = 1'b1;
            if (drop_gate && i == 0) begin gate = 1'b0; wt(2); gate = 1'b1; end
        end
        stop_c;
        if (n > 0 && !drop_gate && prot_n) begin
            for (int s = 0; s < 8; s++)
                if (slot_vld[s]) model[(a & 'h78) | s] = pg[s];
            wt(WRC + 20);
        end
        mptr = page_addr(a & 'h7f, n);
    endtask

    task automatic read_at(int a, int k, string req);
        logic ack;
        logic [7:0] v;
        start_c;
        send_byte(8'hA0, ack); chk({req, " set address ack"}, ack, 1);
        send_byte(8'(a), ack);
        start_c;
        send_byte(8'hA1, ack); chk("R2 read code ack", ack, 1);
        for (int i = 0; i < k; i++) begin
            recv_byte(i < k - 1, v);
            chk(req, v, model[(a + i) & 127]);
        end
        chk("R9 released after master nack", sda_pull, 0);
        stop_c;
        mptr = (a + k) & 127;
    endtask

    task automatic read_cur(int k, string req);
        logic ack;
        logic [7:0] v;
        start_c;
        send_byte(8'hA1, ack); chk("R2 read code ack", ack, 1);
        for (int i = 0; i < k; i++) begin
            recv_byte(i < k - 1, v);
            chk(req, v, model[(mptr + i) & 127]);
        end
        stop_c;
        mptr = (mptr + k) & 127;
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        int a, n, p;
        void'($urandom(32'd7));
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        wt(5);
        chk("R11 line released in reset", sda_pull, 0);
        rst_n = 1'b1;
        wt(5);
        chk("R11 line released after reset", sda_pull, 0);
        read_cur(2, "R11 pointer 0 and array zero");

        // wrong device code
        start_c;
        send_byte(8'hA2, ack); chk("R2 foreign code nack", ack, 0);
        send_byte(8'hA0, ack); chk("R2 silent until next START", ack, 0);
        stop_c;

        // byte write, then address-only transfer that must not write
        wbytes[0] = 8'h5A;
        write_tx(16, 1, 0);
        start_c;
        send_byte(8'hA0, ack); send_byte(8'd16, ack);
        stop_c;
        chk("R1 STOP releases line", sda_pull, 0);
        read_at(16, 1, "R1 R5 byte write kept");

        // page overflow: 11 bytes from offset 5 of page 0x40
        for (int i = 0; i < 11; i++) wbytes[i] = 8'(8'h30 + i);
        write_tx(8'h45, 11, 0);
        read_cur(2, "R5 pointer after last written byte");
        read_at(8'h40, 8, "R4 last eight kept in page");

        // address bit 7 ignored
        wbytes[0] = 8'hC3;
        write_tx(8'h85, 1, 0);
        read_at(8'h05, 1, "R3 address bit 7 ignored");

        // busy polling and gate toggling during the commit
        wbytes[0] = 8'h77; wbytes[1] = 8'h88;
        start_c;
        send_byte(8'hA0, ack); send_byte(8'h20, ack);
        send_byte(wbytes[0], ack); send_byte(wbytes[1], ack);
        stop_c;
        model[8'h20] = 8'h77; model[8'h21] = 8'h88;
        start_c;
        send_byte(8'hA0, ack); chk("R6 no ack while busy", ack, 0);
        stop_c;
        gate = 1'b0; wt(20); gate = 1'b1;
        wt(WRC + 20);
        read_at(8'h20, 2, "R7 gate change does not abort commit");

        // gate low inside transfer and protect low at STOP
        wbytes[0] = 8'hEE;
        write_tx(8'h30, 1, 1);
        read_at(8'h30, 1, "R7 gate drop discards write");
        prot_n = 1'b0;
        write_tx(8'h31, 1, 0);
        prot_n = 1'b1;
        read_at(8'h31, 1, "R8 protect blocks write");

        // repeated START over buffered data
        start_c;
        send_byte(8'hA0, ack); send_byte(8'h22, ack);
        send_byte(8'h99, ack);
        start_c;
        send_byte(8'hA1, ack); chk("R10 repeated START code ack", ack, 1);
        p = page_addr(8'h22, 1);
        recv_byte(1'b0, v);
        chk("R10 buffered byte dropped", v, model[p]);
        stop_c;
        start_c;
        send_byte(8'hA0, ack); chk("R10 no commit started", ack, 1);
        stop_c;

        // read wrap from 0x7F
        wbytes[0] = 8'h1F;
        write_tx(8'h7F, 1, 0);
        read_at(8'h7E, 4, "R9 read wraps 7F to 00");

        // random mix
        for (int t = 0; t < 16; t++) begin
            a = int'($urandom % 128);
            n = 1 + int'($urandom % 12);
            for (int i = 0; i < n; i++) wbytes[i] = 8'($urandom);
            prot_n = ($urandom % 6) != 0;
            write_tx(a, n, ($urandom % 5) == 0);
            prot_n = 1'b1;
            if ($urandom % 2) read_cur(3, "R5 random current read");
            else read_at(int'($urandom % 128), 1 + int'($urandom % 6), "R9 random read");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule